// File: doc/BRIEF.md
# Branch Resolution and Return Prediction Unit

This unit settles control-flow instructions for a machine with fixed 32-bit instructions and a 64-bit program counter. For each decoded branch it receives the branch kind, a condition selector, the source register values, the 21-bit word displacement and the current PC. One cycle later it reports four things. It gives whether the branch is taken and where it goes. It gives the statically predicted direction and target. It gives the link value to write back and the register that receives it.

Three kinds of transfer are handled. Conditional branches test one register and use a PC-relative target. Direct branches are always taken, use a PC-relative target and write a link. Register jumps are always taken, go to the address in a second register and also write a link. Every transfer carries a two-bit role hint. The hint on direct branches and jumps drives a small stack of return addresses. A jump marked as a return is predicted from the top of that stack. Any other jump is predicted from a 14-bit low-address hint carried in the instruction.

Top module: `branch_unit`

## Requirements
- R1: Results appear on the outputs exactly one clock after `in_valid` is sampled high, with `out_valid` high for that one cycle. With no request, `out_valid` is low on the next cycle.
- R2: The branch kind is encoded as 0 none, 1 conditional, 2 direct, 3 register jump. A conditional branch is taken according to `in_cond` applied to `in_ra_val`: 0 equal to zero, 1 negative (bit 63 set), 2 negative or zero, 3 even (bit 0 clear), 4 nonzero, 5 non-negative, 6 positive, 7 odd (bit 0 set).
- R3: For conditional and direct branches, the target is PC+4 plus the sign-extended displacement shifted left by two. This covers the full range from -2^20 to 2^20-1 words.
- R4: A register jump is always taken, and its target is `in_rb_val` with bits 1:0 forced to zero.
- R5: Direct branches and register jumps assert `out_link_we` with `out_link_data` = PC+4 and `out_link_idx` = `in_ra_idx`. The write enable is suppressed when the index is 31. Conditional branches never link.
- R6: A conditional branch is predicted taken when its displacement is negative (backward) and not taken otherwise. Its predicted target is the branch target if predicted taken, else PC+4. Direct branches are predicted taken to their target.
- R7: The role hint is encoded as 0 none, 1 call, 2 return, 3 treated as none. A register jump that is not a return served from a non-empty stack predicts the target {(PC+4)[63:16], `in_jhint`, 2'b00}.
- R8: A direct branch or jump with the call hint pushes PC+4 onto the return stack. A jump with the return hint predicts the current stack top and pops it. `ras_top` and `ras_ok` show the stack top one cycle after the request.
- R9: The stack holds 4 entries. A push when full discards the oldest entry. A pop when empty leaves the stack empty, and an empty stack shows `ras_top` = 0 with `ras_ok` low.
- R10: After reset, `out_valid`, `out_taken`, `out_link_we` and `ras_ok` are low and `ras_top` is zero.
- R11: Role hints on conditional branches and on kind none do not change the stack. Kind none is reported as not taken and not linking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present this cycle |
| in_kind | input | 2 | Branch kind (none, conditional, direct, jump) |
| in_cond | input | 3 | Condition selector for conditional branches |
| in_hint | input | 2 | Role hint (none, call, return) |
| in_ra_idx | input | 5 | Link destination register number |
| in_ra_val | input | 64 | Register value under test |
| in_rb_val | input | 64 | Register jump address |
| in_disp | input | 21 | Signed word displacement |
| in_jhint | input | 14 | Low-address hint of a register jump |
| in_pc | input | 64 | PC of the branch (word aligned) |
| out_valid | output | 1 | Result valid |
| out_taken | output | 1 | Resolved direction |
| out_target | output | 64 | Resolved target |
| out_pred_taken | output | 1 | Static direction prediction |
| out_pred_target | output | 64 | Predicted next fetch address |
| out_link_we | output | 1 | Link write enable |
| out_link_idx | output | 5 | Link destination register |
| out_link_data | output | 64 | Link value (PC+4) |
| ras_top | output | 64 | Current return stack top |
| ras_ok | output | 1 | Return stack non-empty |

## Verification
The hardest state to reach is a return stack that has wrapped. In that state the write pointer has lapped the oldest entry, and the pops that follow must walk back through the surviving entries in reverse order and then fall into the empty state. The stimulus starts with a return on an empty stack. It then issues five consecutive calls with distinct PCs and checks the four returns that follow one by one against the four most recent link values. A final check confirms that the fifth pop finds an empty stack and falls back to the jump hint.

// File: rtl/bru_pkg.sv
package bru_pkg;

    localparam int XLEN     = 64;
    localparam int DISP_W   = 21;
    localparam int JHINT_W  = 14;
    localparam int REG_W    = 5;
    localparam int RAS_DEPTH = 4;

    typedef enum logic [1:0] {
        BK_NONE   = 2'd0,
        BK_COND   = 2'd1,
        BK_DIRECT = 2'd2,
        BK_JUMP   = 2'd3
    } kind_e;

    typedef enum logic [1:0] {
        RH_NONE = 2'd0,
        RH_CALL = 2'd1,
        RH_RET  = 2'd2,
        RH_RSVD = 2'd3
    } role_e;

endpackage

// File: rtl/bru_cond.sv
// Condition evaluator: low two code bits pick a base test, bit 2 inverts it.
module bru_cond #(
    parameter int XLEN = 64
) (
    input  logic [2:0]      code,
    input  logic [XLEN-1:0] val,
    output logic            hit
);
    logic is_zero, is_neg, base;

    always_comb begin
        is_zero = (val == '0);
        is_neg  = val[XLEN-1];
        unique case (code[1:0])
            2'd0:    base = is_zero;
            2'd1:    base = is_neg;
            2'd2:    base = is_neg | is_zero;
            default: base = ~val[0];
        endcase
        hit = base ^ code[2];
    end
endmodule

// File: rtl/bru_target.sv
// Address arithmetic: sequential PC, PC-relative target, register target, hinted target.
module bru_target #(
    parameter int XLEN    = 64,
    parameter int DISP_W  = 21,
    parameter int JHINT_W = 14
) (
    input  logic [XLEN-1:0]    pc,
    input  logic [DISP_W-1:0]  disp,
    input  logic [XLEN-1:0]    rb,
    input  logic [JHINT_W-1:0] jhint,
    output logic [XLEN-1:0]    npc,
    output logic [XLEN-1:0]    rel_tgt,
    output logic [XLEN-1:0]    reg_tgt,
    output logic [XLEN-1:0]    hint_tgt
);
    localparam int HINT_TOP = JHINT_W + 2;
    localparam logic [XLEN-1:0] LOW_MASK = (XLEN'(1) << HINT_TOP) - XLEN'(1);

    logic [XLEN-1:0] offset;

    always_comb begin
        npc      = pc + XLEN'(4);
        offset   = {{(XLEN-DISP_W-2){disp[DISP_W-1]}}, disp, 2'b00};
        rel_tgt  = npc + offset;
        reg_tgt  = rb & ~XLEN'(3);
        hint_tgt = (npc & ~LOW_MASK) | (XLEN'(jhint) << 2);
    end
endmodule

// File: rtl/bru_ras.sv
// Circular return-address stack; DEPTH must be a power of two so the pointer wraps.
module bru_ras #(
    parameter int XLEN  = 64,
    parameter int DEPTH = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  logic            pop,
    input  logic [XLEN-1:0] push_val,
    output logic [XLEN-1:0] top,
    output logic            ok
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][XLEN-1:0] ent;
        logic [PW-1:0]              wp;
        logic [CW-1:0]              cnt;
    } ras_t;

    ras_t s_d, s_q;
    logic [PW-1:0] top_idx;

    always_comb begin
        s_d     = s_q;
        top_idx = s_q.wp - PW'(1);
        ok      = (s_q.cnt != '0);
        top     = ok ? s_q.ent[top_idx] : '0;
        if (push) begin
            s_d.ent[s_q.wp] = push_val;
            s_d.wp          = s_q.wp + PW'(1);
            if (s_q.cnt != CW'(DEPTH)) s_d.cnt = s_q.cnt + CW'(1);
        end else if (pop && ok) begin
            s_d.wp  = top_idx;
            s_d.cnt = s_q.cnt - CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/branch_unit.sv
module branch_unit
    import bru_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [1:0]          in_kind,
    input  logic [2:0]          in_cond,
    input  logic [1:0]          in_hint,
    input  logic [REG_W-1:0]    in_ra_idx,
    input  logic [XLEN-1:0]     in_ra_val,
    input  logic [XLEN-1:0]     in_rb_val,
    input  logic [DISP_W-1:0]   in_disp,
    input  logic [JHINT_W-1:0]  in_jhint,
    input  logic [XLEN-1:0]     in_pc,
    output logic                out_valid,
    output logic                out_taken,
    output logic [XLEN-1:0]     out_target,
    output logic                out_pred_taken,
    output logic [XLEN-1:0]     out_pred_target,
    output logic                out_link_we,
    output logic [REG_W-1:0]    out_link_idx,
    output logic [XLEN-1:0]     out_link_data,
    output logic [XLEN-1:0]     ras_top,
    output logic                ras_ok
);
    localparam logic [REG_W-1:0] ZERO_REG = '1;

    typedef struct packed {
        logic              valid;
        logic              taken;
        logic [XLEN-1:0]   target;
        logic              pred_taken;
        logic [XLEN-1:0]   pred_target;
        logic              link_we;
        logic [REG_W-1:0]  link_idx;
        logic [XLEN-1:0]   link_data;
    } res_t;

    res_t r_d, r_q;

    logic            cond_hit;
    logic [XLEN-1:0] npc, rel_tgt, reg_tgt, hint_tgt;
    logic            hint_live, do_push, do_pop;
    kind_e           kind;
    role_e           role;

    bru_cond #(.XLEN(XLEN)) u_cond (
        .code (in_cond),
        .val  (in_ra_val),
        .hit  (cond_hit)
    );

    bru_target #(.XLEN(XLEN), .DISP_W(DISP_W), .JHINT_W(JHINT_W)) u_tgt (
        .pc       (in_pc),
        .disp     (in_disp),
        .rb       (in_rb_val),
        .jhint    (in_jhint),
        .npc      (npc),
        .rel_tgt  (rel_tgt),
        .reg_tgt  (reg_tgt),
        .hint_tgt (hint_tgt)
    );

    bru_ras #(.XLEN(XLEN), .DEPTH(RAS_DEPTH)) u_ras (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (do_push),
        .pop      (do_pop),
        .push_val (npc),
        .top      (ras_top),
        .ok       (ras_ok)
    );

    always_comb begin
        kind      = kind_e'(in_kind);
        role      = role_e'(in_hint);
        hint_live = in_valid && (kind == BK_DIRECT || kind == BK_JUMP);
        do_push   = hint_live && (role == RH_CALL);
        do_pop    = hint_live && (role == RH_RET);

        r_d           = '0;
        r_d.valid     = in_valid;
        r_d.link_idx  = in_ra_idx;
        r_d.link_data = npc;
        r_d.target    = rel_tgt;
        r_d.pred_target = npc;
        unique case (kind)
            BK_COND: begin
                r_d.taken      = cond_hit;
                r_d.pred_taken = in_disp[DISP_W-1];
                if (in_disp[DISP_W-1]) r_d.pred_target = rel_tgt;
            end
            BK_DIRECT: begin
                r_d.taken       = 1'b1;
                r_d.pred_taken  = 1'b1;
                r_d.pred_target = rel_tgt;
                r_d.link_we     = (in_ra_idx != ZERO_REG);
            end
            BK_JUMP: begin
                r_d.taken       = 1'b1;
                r_d.pred_taken  = 1'b1;
                r_d.target      = reg_tgt;
                r_d.pred_target = (role == RH_RET && ras_ok) ? ras_top : hint_tgt;
                r_d.link_we     = (in_ra_idx != ZERO_REG);
            end
            default: begin
                r_d.target = npc;
            end
        endcase
        if (!in_valid) r_d.link_we = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign out_valid       = r_q.valid;
    assign out_taken       = r_q.taken;
    assign out_target      = r_q.target;
    assign out_pred_taken  = r_q.pred_taken;
    assign out_pred_target = r_q.pred_target;
    assign out_link_we     = r_q.link_we;
    assign out_link_idx    = r_q.link_idx;
    assign out_link_data   = r_q.link_data;
endmodule

// File: rtl/bru_checker.sv
module bru_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        out_valid,
    input logic        out_taken,
    input logic [63:0] out_target,
    input logic        out_link_we,
    input logic [4:0]  out_link_idx,
    input logic [63:0] ras_top,
    input logic        ras_ok
);
    a_r1_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    a_r5_no_zero_link: assert property (@(posedge clk) disable iff (!rst_n)
        out_link_we |-> (out_link_idx != 5'd31));

    a_r5_link_taken: assert property (@(posedge clk) disable iff (!rst_n)
        out_link_we |-> (out_valid && out_taken));

    a_r4_target_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_target[1:0] == 2'b00));

    a_r9_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !ras_ok |-> (ras_top == 64'd0));
endmodule

bind branch_unit bru_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .out_valid    (out_valid),
    .out_taken    (out_taken),
    .out_target   (out_target),
    .out_link_we  (out_link_we),
    .out_link_idx (out_link_idx),
    .ras_top      (ras_top),
    .ras_ok       (ras_ok)
);

// File: tb/tb_branch_unit.sv
module tb_branch_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  in_kind = '0;
    logic [2:0]  in_cond = '0;
    logic [1:0]  in_hint = '0;
    logic [4:0]  in_ra_idx = '0;
    logic [63:0] in_ra_val = '0, in_rb_val = '0, in_pc = '0;
    logic [20:0] in_disp = '0;
    logic [13:0] in_jhint = '0;
    logic        out_valid, out_taken, out_pred_taken, out_link_we, ras_ok;
    logic [63:0] out_target, out_pred_target, out_link_data, ras_top;
    logic [4:0]  out_link_idx;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    branch_unit dut (.*);

    typedef struct packed {
        logic [2:0]  cond;
        logic [63:0] ra;
        logic [20:0] disp;
        logic [63:0] pc;
        logic        taken;
        logic [63:0] tgt;
        logic        pred;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 64'd0,                  21'd4,       64'h1000, 1'b1, 64'h1014, 1'b0},
        '{3'd0, 64'd5,                  21'd4,       64'h1000, 1'b0, 64'h1014, 1'b0},
        '{3'd4, 64'd0,                  21'd4,       64'h1000, 1'b0, 64'h1014, 1'b0},
        '{3'd4, 64'h8000000000000000,   21'd4,       64'h1000, 1'b1, 64'h1014, 1'b0},
        '{3'd1, 64'hFFFFFFFFFFFFFFFF,   21'd4,       64'h1000, 1'b1, 64'h1014, 1'b0},
        '{3'd1, 64'd0,                  21'd4,       64'h1000, 1'b0, 64'h1014, 1'b0},
        '{3'd2, 64'd0,                  21'd4,       64'h1000, 1'b1, 64'h1014, 1'b0},
        '{3'd2, 64'd1,                  21'd4,       64'h1000, 1'b0, 64'h1014, 1'b0},
        '{3'd5, 64'd0,                  21'd4,       64'h1000, 1'b1, 64'h1014, 1'b0},
        '{3'd5, 64'h8000000000000000,   21'd4,       64'h1000, 1'b0, 64'h1014, 1'b0},
        '{3'd6, 64'd0,                  21'd4,       64'h1000, 1'b0, 64'h1014, 1'b0},
        '{3'd6, 64'h7FFFFFFFFFFFFFFF,   21'd4,       64'h1000, 1'b1, 64'h1014, 1'b0},
        '{3'd3, 64'd2,                  21'd4,       64'h1000, 1'b1, 64'h1014, 1'b0},
        '{3'd3, 64'd3,                  21'd4,       64'h1000, 1'b0, 64'h1014, 1'b0},
        '{3'd7, 64'hFFFFFFFFFFFFFFFF,   21'd4,       64'h1000, 1'b1, 64'h1014, 1'b0},
        '{3'd7, 64'h10,                 21'd4,       64'h1000, 1'b0, 64'h1014, 1'b0},
        '{3'd0, 64'd0,                  21'h1FFFFF,  64'h1000, 1'b1, 64'h1000, 1'b1},
        '{3'd0, 64'd0,                  21'h100000,  64'h10000000, 1'b1, 64'h0FC00004, 1'b1},
        '{3'd0, 64'd0,                  21'h0FFFFF,  64'h10000000, 1'b1, 64'h10400000, 1'b0}
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // drive at a falling edge, results are registered at the next rising edge
    task automatic issue(input logic [1:0] kind, input logic [2:0] cond, input logic [1:0] hint,
                         input logic [4:0] ra_idx, input logic [63:0] ra, input logic [63:0] rb,
                         input logic [20:0] disp, input logic [13:0] jh, input logic [63:0] pc);
        in_valid = 1'b1; in_kind = kind; in_cond = cond; in_hint = hint;
        in_ra_idx = ra_idx; in_ra_val = ra; in_rb_val = rb; in_disp = disp;
        in_jhint = jh; in_pc = pc;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 out_valid", 64'(out_valid), 64'd0);
        chk("R10 out_taken", 64'(out_taken), 64'd0);
        chk("R10 link_we", 64'(out_link_we), 64'd0);
        chk("R10 ras_ok", 64'(ras_ok), 64'd0);
        chk("R10 ras_top", ras_top, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // table of conditional branches: R2 conditions, R3 targets, R6 prediction
        for (int i = 0; i < NV; i++) begin
            issue(2'd1, VECS[i].cond, 2'd0, 5'd3, VECS[i].ra, 64'd0, VECS[i].disp, 14'd0, VECS[i].pc);
            chk("R1 out_valid", 64'(out_valid), 64'd1);
            chk("R2 taken", 64'(out_taken), 64'(VECS[i].taken));
            chk("R3 target", out_target, VECS[i].tgt);
            chk("R6 pred_taken", 64'(out_pred_taken), 64'(VECS[i].pred));
            chk("R6 pred_target", out_pred_target, VECS[i].pred ? VECS[i].tgt : VECS[i].pc + 64'd4);
            chk("R5 cond no link", 64'(out_link_we), 64'd0);
        end
        @(negedge clk);
        chk("R1 idle", 64'(out_valid), 64'd0);

        // direct branch with link
        issue(2'd2, 3'd0, 2'd0, 5'd26, 64'd0, 64'd0, 21'd8, 14'd0, 64'h2000);
        chk("R3 direct target", out_target, 64'h2024);
        chk("R6 direct pred", out_pred_target, 64'h2024);
        chk("R5 link_we", 64'(out_link_we), 64'd1);
        chk("R5 link_idx", 64'(out_link_idx), 64'd26);
        chk("R5 link_data", out_link_data, 64'h2004);
        issue(2'd2, 3'd0, 2'd0, 5'd31, 64'd0, 64'd0, 21'd8, 14'd0, 64'h2000);
        chk("R5 r31 no link", 64'(out_link_we), 64'd0);

        // register jump, hint prediction
        issue(2'd3, 3'd0, 2'd0, 5'd31, 64'd0, 64'h12345677, 21'd0, 14'h2AB, 64'hABCD0000);
        chk("R4 jump taken", 64'(out_taken), 64'd1);
        chk("R4 jump target", out_target, 64'h12345674);
        chk("R7 hint target", out_pred_target, 64'hABCD0AAC);

        // R9 return on empty stack falls back to hint
        issue(2'd3, 3'd0, 2'd2, 5'd31, 64'd0, 64'h40, 21'd0, 14'h10, 64'h5000);
        chk("R9 empty pop pred", out_pred_target, 64'h40);
        chk("R9 empty ok", 64'(ras_ok), 64'd0);

        // R8 five calls wrap the four-entry stack
        for (int i = 1; i <= 5; i++)
            issue(2'd2, 3'd0, 2'd1, 5'd26, 64'd0, 64'd0, 21'd1, 14'd0, 64'(i) * 64'h100);
        chk("R8 top after calls", ras_top, 64'h504);
        chk("R8 ok after calls", 64'(ras_ok), 64'd1);
        for (int i = 5; i >= 2; i--) begin
            issue(2'd3, 3'd0, 2'd2, 5'd31, 64'd0, 64'h0, 21'd0, 14'h3, 64'h9000);
            chk("R8 return pred", out_pred_target, 64'(i) * 64'h100 + 64'd4);
        end
        chk("R9 drained ok", 64'(ras_ok), 64'd0);
        chk("R9 drained top", ras_top, 64'd0);
        issue(2'd3, 3'd0, 2'd2, 5'd31, 64'd0, 64'h0, 21'd0, 14'h3, 64'h9000);
        chk("R9 oldest discarded", out_pred_target, 64'hC);

        // R11 hints ignored on none and conditional kinds
        issue(2'd0, 3'd0, 2'd1, 5'd5, 64'd0, 64'd0, 21'd4, 14'd0, 64'h7000);
        chk("R11 none taken", 64'(out_taken), 64'd0);
        chk("R11 none link", 64'(out_link_we), 64'd0);
        chk("R11 none ras", 64'(ras_ok), 64'd0);
        issue(2'd1, 3'd0, 2'd1, 5'd5, 64'd0, 64'd0, 21'd4, 14'd0, 64'h7000);
        chk("R11 cond ras", 64'(ras_ok), 64'd0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule